// File: doc/BRIEF.md
# Store Address and Data Formatter

This block sits between instruction decode and a 64-bit memory write port. It takes one decoded integer store and, one cycle later, presents the effective address, the write data already placed on the byte lanes of the port, and the byte enables. It also presents the value to write back into the base register for update-form stores. Inputs arrive through a valid/ready handshake, and results leave through a second valid/ready handshake.

The address is a base plus an offset. The base is either the RA value or the constant zero. The offset is a sign-extended immediate, the RB value, or a sign-extended immediate whose two low bits are forced to zero. The store data is the low 1, 2, 4 or 8 bytes of RS. Those bytes are placed in big-endian order, or in reversed order when byte reversal is requested.

Top module: `store_formatter`

## Requirements
- R1: In a non-update store, the base is zero when `in_ra_zero` is 1 and the RA value otherwise.
- R2: `in_form` 0 uses the 16-bit immediate sign-extended to 64 bits as the offset. `in_form` 1 uses the RB value as the offset.
- R3: `in_form` 2 and 3 ignore immediate bits 1..0, treat them as zero, and sign-extend the result to form the offset.
- R4: In an update store (`in_update`=1), the base is always the RA value. `out_wb_valid` is 1 and `out_wb_value` equals `out_addr`, unless `in_ra_zero` is 1. In that case `out_upd_invalid` is 1 and `out_wb_valid` is 0. The two flags are never both 1.
- R5: `in_size` encodes the store width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The stored value is the low bytes of RS. Lane k, `out_data[8k+7:8k]`, holds the byte at address (EA with bits 2..0 cleared)+k. With reversal off, the most significant stored byte goes to EA.
- R6: With `in_brev`=1, the least significant RS byte goes to EA and the rest follow in rising significance. For 1-byte stores the flag has no effect.
- R7: `out_be` bit k is set exactly for the stored bytes whose address falls on lane k. Data lanes that are not enabled read zero.
- R8: `out_misalign` is 1 when EA[2:0] plus the size is greater than 8. Bytes past lane 7 are dropped.
- R9: A store accepted at one clock edge is valid at the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output holds steady.
- R10: Synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Store request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_size | input | 2 | Width code (0:1B, 1:2B, 2:4B, 3:8B) |
| in_form | input | 2 | Offset select (0 imm, 1 RB, 2/3 scaled imm) |
| in_update | input | 1 | Update form |
| in_brev | input | 1 | Byte-reversed store |
| in_ra_zero | input | 1 | RA field is register 0 |
| in_ra | input | 64 | RA value |
| in_rb | input | 64 | RB value |
| in_rs | input | 64 | Source data value |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 64 | Effective address |
| out_data | output | 64 | Lane-placed write data |
| out_be | output | 8 | Byte enables per lane |
| out_misalign | output | 1 | Access crosses an 8-byte line |
| out_wb_valid | output | 1 | Base writeback valid |
| out_wb_value | output | 64 | New base register value |
| out_upd_invalid | output | 1 | Update form with RA = register 0 |

## Verification
The hardest case to reach is a store that is both misaligned and byte-reversed and that arrives while the output is held by back-pressure. In that case the truncated lanes, the reversed byte order and the held outputs must all stay correct together. The bench reaches it with a run of random stores over every size, form and offset while `out_ready` toggles randomly. A scoreboard compares each result with a model built from the requirements. A directed stall with `out_ready` held low then checks that the outputs stay steady and that `in_ready` drops.

// File: rtl/stfmt_pkg.sv
package stfmt_pkg;

    localparam int XLEN    = 64;
    localparam int LANES   = XLEN / 8;
    localparam int LANE_AW = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    typedef enum logic [1:0] {
        AF_DISP   = 2'd0,
        AF_INDEX  = 2'd1,
        AF_SCALED = 2'd2,
        AF_SCALE2 = 2'd3
    } st_form_e;

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  data;
        logic [LANES-1:0] be;
        logic             misalign;
        logic             wb_valid;
        logic             upd_bad;
    } st_result_t;

    function automatic logic [XLEN-1:0] be_to_mask(input logic [LANES-1:0] be);
        logic [XLEN-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/stfmt_agen.sv
module stfmt_agen
    import stfmt_pkg::*;
#(
    parameter int AW    = XLEN,
    parameter int IMM_W = 16
) (
    input  st_form_e         form,
    input  logic             update,
    input  logic             ra_zero,
    input  logic [AW-1:0]    ra,
    input  logic [AW-1:0]    rb,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    ea,
    output logic             wb_valid,
    output logic             upd_bad
);
    localparam int EXT_W = AW - IMM_W;

    logic [AW-1:0] base;
    logic [AW-1:0] offset;

    always_comb begin
        // update forms always use the register; others substitute zero
        base = (update || !ra_zero) ? ra : '0;
        unique case (form)
            AF_DISP:  offset = {{EXT_W{imm[IMM_W-1]}}, imm};
            AF_INDEX: offset = rb;
            default:  offset = {{EXT_W{imm[IMM_W-1]}}, imm[IMM_W-1:2], 2'b00};
        endcase
        ea       = base + offset;
        wb_valid = update && !ra_zero;
        upd_bad  = update && ra_zero;
    end

endmodule

// File: rtl/stfmt_lanes.sv
module stfmt_lanes
    import stfmt_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  st_size_e                   size,
    input  logic                       brev,
    input  logic [$clog2(DW/8)-1:0]    off,
    input  logic [DW-1:0]              rs,
    output logic [DW-1:0]              data,
    output logic [DW/8-1:0]            be,
    output logic                       misalign
);
    localparam int NL = DW / 8;
    localparam int LW = $clog2(NL);

    logic [LW:0] nbytes;

    assign nbytes   = (LW+1)'(1) << size;
    assign misalign = ({1'b0, off} + nbytes) > (LW+1)'(NL);

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic [LW-1:0] rel;
        logic [LW-1:0] src;
        logic          hit;
        logic [7:0]    lane_byte;

        always_comb begin
            rel = LW'(k) - off;
            hit = (LW'(k) >= off) && ({1'b0, rel} < nbytes);
            // reversed: byte i of the value goes to EA+i; normal: mirrored
            src = brev ? rel : (LW'(nbytes - 1'b1) - rel);
            lane_byte = hit ? rs[{src, 3'b000} +: 8] : 8'h00;
        end

        assign be[k]          = hit;
        assign data[8*k +: 8] = lane_byte;
    end

endmodule

// File: rtl/stfmt_stage.sv
module stfmt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            out_data <= in_data;
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/store_formatter.sv
module store_formatter
    import stfmt_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_size,
    input  logic [1:0]        in_form,
    input  logic              in_update,
    input  logic              in_brev,
    input  logic              in_ra_zero,
    input  logic [XLEN-1:0]   in_ra,
    input  logic [XLEN-1:0]   in_rb,
    input  logic [XLEN-1:0]   in_rs,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [XLEN-1:0]   out_addr,
    output logic [XLEN-1:0]   out_data,
    output logic [LANES-1:0]  out_be,
    output logic              out_misalign,
    output logic              out_wb_valid,
    output logic [XLEN-1:0]   out_wb_value,
    output logic              out_upd_invalid
);
    localparam int RES_W = $bits(st_result_t);

    st_result_t    nxt;
    st_result_t    cur;
    logic [XLEN-1:0] ea;

    stfmt_agen #(.AW(XLEN), .IMM_W(IMM_W)) u_agen (
        .form     (st_form_e'(in_form)),
        .update   (in_update),
        .ra_zero  (in_ra_zero),
        .ra       (in_ra),
        .rb       (in_rb),
        .imm      (in_imm),
        .ea       (ea),
        .wb_valid (nxt.wb_valid),
        .upd_bad  (nxt.upd_bad)
    );

    stfmt_lanes #(.DW(XLEN)) u_lanes (
        .size     (st_size_e'(in_size)),
        .brev     (in_brev),
        .off      (ea[LANE_AW-1:0]),
        .rs       (in_rs),
        .data     (nxt.data),
        .be       (nxt.be),
        .misalign (nxt.misalign)
    );

    assign nxt.addr = ea;

    stfmt_stage #(.W(RES_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (nxt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (cur)
    );

    assign out_addr        = cur.addr;
    assign out_data        = cur.data;
    assign out_be          = cur.be;
    assign out_misalign    = cur.misalign;
    assign out_wb_valid    = cur.wb_valid;
    assign out_wb_value    = cur.addr;
    assign out_upd_invalid = cur.upd_bad;

    // R4
    wb_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_wb_valid && out_upd_invalid));

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data & ~be_to_mask(out_be)) == '0);

    // R7
    be_size_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_misalign |->
            $countones(out_be) == 1 || $countones(out_be) == 2 ||
            $countones(out_be) == 4 || $countones(out_be) == 8);

    // R8
    misalign_top_lane_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_misalign |-> out_be[LANES-1] && !out_be[0]);

endmodule

// File: tb/tb_store_formatter.sv
module tb_store_formatter;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] addr;
        logic [63:0] data;
        logic [7:0]  be;
        logic        mis;
        logic        wbv;
        logic        bad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_form = '0;
    logic        in_update = 1'b0;
    logic        in_brev = 1'b0;
    logic        in_ra_zero = 1'b0;
    logic [63:0] in_ra = '0;
    logic [63:0] in_rb = '0;
    logic [63:0] in_rs = '0;
    logic [15:0] in_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_addr;
    logic [63:0] out_data;
    logic [7:0]  out_be;
    logic        out_misalign;
    logic        out_wb_valid;
    logic [63:0] out_wb_value;
    logic        out_upd_invalid;

    int   errors = 0;
    int   checks = 0;
    logic stall_mode = 1'b0;
    logic hold_ready = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    store_formatter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_size(in_size), .in_form(in_form), .in_update(in_update),
        .in_brev(in_brev), .in_ra_zero(in_ra_zero), .in_ra(in_ra),
        .in_rb(in_rb), .in_rs(in_rs), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_data(out_data), .out_be(out_be), .out_misalign(out_misalign),
        .out_wb_valid(out_wb_valid), .out_wb_value(out_wb_value),
        .out_upd_invalid(out_upd_invalid)
    );

    always @(posedge clk) begin
        #1;
        out_ready = hold_ready ? 1'b0 : (stall_mode ? ($urandom_range(0, 1) == 1) : 1'b1);
    end

    function automatic exp_t model(input logic [1:0] sz, input logic [1:0] fm,
                                   input logic upd, input logic brev, input logic raz,
                                   input logic [63:0] ra, input logic [63:0] rb,
                                   input logic [63:0] rs, input logic [15:0] imm);
        exp_t        m;
        int          n;
        logic [63:0] base, offs, a;
        n    = 1 << sz;
        base = (upd || !raz) ? ra : 64'd0;
        if (fm == 2'd0)      offs = {{48{imm[15]}}, imm};
        else if (fm == 2'd1) offs = rb;
        else                 offs = {{48{imm[15]}}, imm[15:2], 2'b00};
        m.addr = base + offs;
        m.data = '0;
        m.be   = '0;
        for (int i = 0; i < n; i++) begin
            a = m.addr + 64'(i);
            if (a[63:3] == m.addr[63:3]) begin
                m.data[8*a[2:0] +: 8] = brev ? rs[8*i +: 8] : rs[8*(n-1-i) +: 8];
                m.be[a[2:0]] = 1'b1;
            end
        end
        m.mis = (int'(m.addr[2:0]) + n) > 8;
        m.wbv = upd && !raz;
        m.bad = upd && raz;
        return m;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(input string tag, input logic [1:0] sz, input logic [1:0] fm,
                        input logic upd, input logic brev, input logic raz,
                        input logic [63:0] ra, input logic [63:0] rb,
                        input logic [63:0] rs, input logic [15:0] imm);
        @(negedge clk);
        in_size = sz; in_form = fm; in_update = upd; in_brev = brev;
        in_ra_zero = raz; in_ra = ra; in_rb = rb; in_rs = rs; in_imm = imm;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(model(sz, fm, upd, brev, raz, ra, rb, rs, imm));
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R9", "unexpected_output", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "addr", out_addr, e.addr);
                check(t, "data", out_data, e.data);
                check(t, "be", 64'(out_be), 64'(e.be));
                check(t, "misalign(R8)", 64'(out_misalign), 64'(e.mis));
                check(t, "wb_valid(R4)", 64'(out_wb_valid), 64'(e.wbv));
                check(t, "upd_invalid(R4)", 64'(out_upd_invalid), 64'(e.bad));
                if (e.wbv) check(t, "wb_value(R4)", out_wb_value, e.addr);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=drained");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset leaves no result pending
        check("R10", "out_valid_after_reset", 64'(out_valid), 64'd0);
        check("R9", "in_ready_idle", 64'(in_ready), 64'd1);

        // R1 base substitution
        send("R1", 2'd3, 2'd0, 0, 0, 1, 64'h1000, 0, 64'h1122334455667788, 16'h0010);
        send("R1", 2'd3, 2'd0, 0, 0, 0, 64'h1000, 0, 64'h1122334455667788, 16'h0010);
        // R2 negative displacement and indexed
        send("R2", 2'd2, 2'd0, 0, 0, 0, 64'h2000, 0, 64'hAABBCCDD, 16'hFFF8);
        send("R2", 2'd1, 2'd1, 0, 0, 0, 64'h3000, 64'h0000_0000_0000_0102, 64'h5A6B, 16'h7777);
        // R3 scaled immediate low bits dropped
        send("R3", 2'd3, 2'd2, 0, 0, 0, 64'h4000, 0, 64'h0102030405060708, 16'h0007);
        send("R3", 2'd3, 2'd3, 0, 0, 0, 64'h4000, 0, 64'h0102030405060708, 16'hFFFF);
        // R4 update forms
        send("R4", 2'd0, 2'd0, 1, 0, 1, 64'h5000, 0, 64'h99, 16'h0003);
        send("R4", 2'd2, 2'd1, 1, 0, 0, 64'h5000, 64'h24, 64'hDEADBEEF, 0);
        // R5 big-endian word at lane 4
        send("R5", 2'd2, 2'd0, 0, 0, 0, 64'h6004, 0, 64'hFFFF_FFFF_1234_5678, 0);
        // R6 reversed doubleword, halfword at lane 6, and a byte
        send("R6", 2'd3, 2'd0, 0, 1, 0, 64'h7000, 0, 64'h0011223344556677, 0);
        send("R6", 2'd1, 2'd0, 0, 1, 0, 64'h7006, 0, 64'hABCD, 0);
        send("R6", 2'd0, 2'd0, 0, 1, 0, 64'h7005, 0, 64'h00000000000000E1, 0);
        // R7 full doubleword lanes; R8 word crossing the line
        send("R7", 2'd3, 2'd1, 0, 0, 0, 64'h8000, 64'h8, 64'hCAFEF00D12345678, 0);
        send("R8", 2'd2, 2'd0, 0, 0, 0, 64'h9006, 0, 64'h0A0B0C0D, 0);
        send("R8", 2'd3, 2'd0, 0, 1, 0, 64'h9003, 0, 64'h0102030405060708, 0);

        // R9 latency: accepted at an edge, valid at the next negedge
        send("R9", 2'd0, 2'd0, 0, 0, 0, 64'hA000, 0, 64'h42, 0);
        check("R9", "one_cycle_latency", 64'(out_valid), 64'd1);

        // R9 stall: outputs hold, in_ready drops
        @(negedge clk);
        hold_ready = 1'b1;
        @(posedge clk);
        send("R9", 2'd2, 2'd1, 0, 1, 0, 64'hB000, 64'h4, 64'h11223344, 0);
        @(negedge clk);
        held = out_addr;
        for (int c = 0; c < 3; c++) begin
            check("R9", "stall_valid", 64'(out_valid), 64'd1);
            check("R9", "stall_in_ready", 64'(in_ready), 64'd0);
            check("R9", "stall_addr_stable", out_addr, held);
            @(negedge clk);
        end
        hold_ready = 1'b0;

        // random traffic under back-pressure
        stall_mode = 1'b1;
        for (int k = 0; k < 400; k++) begin
            send("R5 R6 R7 R8", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)),
                 {$urandom, $urandom}, {$urandom, $urandom},
                 {$urandom, $urandom}, 16'($urandom));
        end
        stall_mode = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule